// File: doc/BRIEF.md
# Variable-Rate CPU Clock Generator with Hand Stepping

This block derives the clock for a small 8-bit processor from a 16 MHz reference. The output is a square wave whose high and low phases always last the same number of reference cycles, so the duty cycle stays at one half at every rate. A speed select input stands in for switches or an encoder. It picks a half period of `MIN_HALF * 2^sel` reference cycles. With the defaults this spans 1 MHz (sel 0) down to just under 1 Hz (sel 20). Select values above `MAX_SEL` are clamped.

A mode input chooses between free running and hand stepping. In hand-stepping mode the output rests low. Each accepted press of the step button, after a two-stage synchroniser and a stability filter, produces exactly one high phase followed by one low phase of the selected length. A new rate or mode is only adopted where a low phase ends, so the processor never sees a shortened pulse.

The controller has three named states:
- IDLE: output low, waiting.
- HIGH: output high for one half period.
- LOW: output low for one half period.

The transitions are:
- IDLE to HIGH, on free-running mode or on an accepted press.
- HIGH to LOW, when the half period expires.
- LOW to HIGH, at expiry in free-running mode.
- LOW to IDLE, at expiry in hand-stepping mode.

While in IDLE, and in the cycle that ends a LOW phase, the block loads the current select value.

Top module: `ckgen_cpu_clock`

## Requirements
- R1: While `rst_n` is low, `cpu_clk` is low. After reset is released in free-running mode, the first high phase begins at the first reference edge and lasts a full half period.
- R2: In free-running mode, each high phase and each low phase lasts exactly `MIN_HALF << sel` reference cycles, with `sel` read as an unsigned number.
- R3: A select value greater than `MAX_SEL` gives the half period of `MAX_SEL`.
- R4: A select change made during a high or a low phase does not alter that phase or the low phase that follows it. The new length applies from the next high phase onward, and no phase is ever cut short.
- R5: Entering hand-stepping mode during a high phase lets that high phase and the following low phase run to full length. After that, `cpu_clk` stays low.
- R6: In hand-stepping mode, one accepted press gives exactly one high phase of full length, followed by a low phase, after which `cpu_clk` stays low.
- R7: A press is accepted only after the synchronised button has read 1 for `DEB_CYCLES` consecutive reference cycles. A pulse of `DEB_CYCLES-1` cycles, or bouncing with shorter runs, produces no step.
- R8: Holding the button down produces a single step. Another step needs a release followed by a new press.
- R9: A press accepted while a step is in progress is discarded, not queued.
- R10: When the mode returns to free running, output resumes with a full-length high phase. If a step's low phase is in progress at the time, that low phase first completes in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock (16 MHz in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_sel | input | SEL_W | Rate select; half period is MIN_HALF << min(sel, MAX_SEL) |
| manual_mode | input | 1 | 1 = hand stepping, 0 = free running |
| step_btn | input | 1 | Raw, asynchronous, bouncing step push button (1 = pressed) |
| cpu_clk | output | 1 | Generated processor clock |

## Verification
Several properties are checked on every cycle:
- While a phase timer runs, the output holds its level, so a phase cannot end early.
- The latched rate stays constant everywhere except the IDLE state and the cycle that ends a LOW phase.
- An idle, hand-stepped output never rises without an accepted press.
- The filter emits single-cycle press pulses.
- The phase counter stays below its limit.

Other behaviours can only be shown by the bench's scenarios, since they depend on sequences of stimuli:
- Exact phase lengths at several rates, including the clamp.
- The point at which a mid-phase rate change takes effect.
- The boundary between a rejected press of `DEB_CYCLES-1` cycles and an accepted press of `DEB_CYCLES` cycles.
- That presses made during a step are dropped.
- The order of phases when switching between modes.

// File: rtl/ckgen_pkg.sv
package ckgen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

endpackage

// File: rtl/ckgen_btn_cond.sv
module ckgen_btn_cond #(
    parameter int DEB_CYCLES = 16000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    output logic press
);
    localparam int CW = $clog2(DEB_CYCLES + 1);

    logic [1:0]    sync_q;
    logic          stable_q;
    logic [CW-1:0] cnt_q;
    logic          press_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q   <= '0;
            stable_q <= 1'b0;
            cnt_q    <= '0;
            press_q  <= 1'b0;
        end else begin
            sync_q  <= {sync_q[0], btn_raw};
            press_q <= 1'b0;
            if (sync_q[1] == stable_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(DEB_CYCLES - 1)) begin
                stable_q <= sync_q[1];
                cnt_q    <= '0;
                press_q  <= sync_q[1];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign press = press_q;

    // R8: an accepted press is a single-cycle event
    a_r8_press_single: assert property (@(posedge clk) disable iff (!rst_n)
        press_q |=> !press_q);

    // R7: a press pulse only accompanies a filtered level that is high
    a_r7_press_level: assert property (@(posedge clk) disable iff (!rst_n)
        press_q |-> stable_q);

endmodule

// File: rtl/ckgen_rate_map.sv
module ckgen_rate_map #(
    parameter int SEL_W    = 5,
    parameter int MIN_HALF = 8,
    parameter int MAX_SEL  = 20,
    parameter int HALF_W   = 24
) (
    input  logic [SEL_W-1:0]  sel,
    output logic [HALF_W-1:0] half_cycles
);
    logic [SEL_W-1:0] sel_eff;

    always_comb begin
        sel_eff     = (sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel;
        half_cycles = HALF_W'(MIN_HALF) << sel_eff;
    end

endmodule

// File: rtl/ckgen_phase_timer.sv
module ckgen_phase_timer #(
    parameter int HALF_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    input  logic [HALF_W-1:0] limit,
    output logic              done
);
    logic [HALF_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (run)     cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == limit - 1'b1);

    // R2: the phase counter never runs past the programmed half period
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart) |=> (!run || cnt_q < limit));

endmodule

// File: rtl/ckgen_cpu_clock.sv
module ckgen_cpu_clock
    import ckgen_pkg::*;
#(
    parameter int SEL_W      = 5,
    parameter int MIN_HALF   = 8,
    parameter int MAX_SEL    = 20,
    parameter int DEB_CYCLES = 16000
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] speed_sel,
    input  logic             manual_mode,
    input  logic             step_btn,
    output logic             cpu_clk
);
    localparam int HALF_W = $clog2(MIN_HALF) + MAX_SEL + 1;

    phase_e            phase_q, phase_d;
    logic [SEL_W-1:0]  act_sel_q;
    logic [HALF_W-1:0] act_half;
    logic              phase_done;
    logic              press;
    logic              load_cfg;
    logic              restart;
    logic              run;
    logic              cpu_clk_q;

    ckgen_btn_cond #(.DEB_CYCLES(DEB_CYCLES)) u_btn (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .btn_raw (step_btn),
        .press   (press)
    );

    ckgen_rate_map #(
        .SEL_W(SEL_W), .MIN_HALF(MIN_HALF), .MAX_SEL(MAX_SEL), .HALF_W(HALF_W)
    ) u_rate (
        .sel         (act_sel_q),
        .half_cycles (act_half)
    );

    ckgen_phase_timer #(.HALF_W(HALF_W)) u_timer (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (run),
        .limit   (act_half),
        .done    (phase_done)
    );

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (!manual_mode || press) phase_d = PH_HIGH;
            PH_HIGH: if (phase_done)            phase_d = PH_LOW;
            PH_LOW:  if (phase_done)            phase_d = manual_mode ? PH_IDLE : PH_HIGH;
            default:                            phase_d = PH_IDLE;
        endcase
    end

    assign load_cfg = (phase_q == PH_IDLE) || (phase_q == PH_LOW && phase_done);
    assign restart  = (phase_d != phase_q);
    assign run      = (phase_q != PH_IDLE);

    // state register and latched rate
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            act_sel_q <= '0;
        end else begin
            phase_q <= phase_d;
            if (load_cfg) act_sel_q <= speed_sel;
        end
    end

    // registered output
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) cpu_clk_q <= 1'b0;
        else        cpu_clk_q <= (phase_d == PH_HIGH);
    end

    assign cpu_clk = cpu_clk_q;

    // R2: a high phase holds until its timer expires
    a_r2_high_holds: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (phase_q == PH_HIGH && !phase_done) |=> cpu_clk);

    // R4: a low phase is never cut short
    a_r4_low_holds: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (phase_q == PH_LOW && !phase_done) |=> !cpu_clk);

    // R4: the rate is only adopted in IDLE or at the end of a low phase
    a_r4_cfg_stable: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (phase_q != PH_IDLE && !(phase_q == PH_LOW && phase_done)) |=> $stable(act_sel_q));

    // R6: a resting hand-stepped output does not rise without a press
    a_r6_idle_quiet: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (phase_q == PH_IDLE && manual_mode && !press) |=> !cpu_clk);

endmodule

// File: tb/ckgen_cpu_clock_tb_top.sv
module ckgen_cpu_clock_tb_top;
    localparam int SEL_W = 3;
    localparam int MINH  = 8;
    localparam int MAXS  = 4;
    localparam int DEB   = 6;
    localparam int LIM   = 400;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [SEL_W-1:0] sel = '0;
    logic             manual = 1'b0;
    logic             btn = 1'b0;
    logic             cpu_clk;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ckgen_cpu_clock #(
        .SEL_W(SEL_W), .MIN_HALF(MINH), .MAX_SEL(MAXS), .DEB_CYCLES(DEB)
    ) dut_i (
        .clk_ref     (clk),
        .rst_n       (rst_n),
        .speed_sel   (sel),
        .manual_mode (manual),
        .step_btn    (btn),
        .cpu_clk     (cpu_clk)
    );

    function automatic int exp_half(input int s);
        return MINH << ((s > MAXS) ? MAXS : s);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic smp();
        @(negedge clk);
    endtask

    task automatic wait_rise(input int lim, output bit ok);
        int n = 0;
        while (cpu_clk == 1'b1 && n < lim) begin smp(); n++; end
        while (cpu_clk == 1'b0 && n < lim) begin smp(); n++; end
        ok = (cpu_clk == 1'b1);
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (cpu_clk == lvl && n < LIM) begin n++; smp(); end
    endtask

    task automatic count_rises(input int len, output int r);
        logic prev;
        r = 0;
        prev = cpu_clk;
        repeat (len) begin
            smp();
            if (cpu_clk && !prev) r++;
            prev = cpu_clk;
        end
    endtask

    task automatic t_reset();
        bit ok;
        int hi;
        int bad = 0;
        rst_n = 1'b0;
        repeat (5) begin smp(); if (cpu_clk) bad++; end
        check(bad == 0, "R1 low in reset", bad, 0);
        rst_n = 1'b1;
        wait_rise(4, ok);
        check(ok, "R1 first high after reset", ok, 1);
        run_len(1'b1, hi);
        check(hi == exp_half(0), "R1 first high length", hi, exp_half(0));
    endtask

    task automatic t_auto(input int s, input string req);
        bit ok;
        int hi;
        int lo;
        sel = SEL_W'(s);
        wait_rise(LIM, ok);
        wait_rise(LIM, ok);
        run_len(1'b1, hi);
        run_len(1'b0, lo);
        check(hi == exp_half(s), req, hi, exp_half(s));
        check(lo == exp_half(s), req, lo, exp_half(s));
    endtask

    task automatic t_change_mid_high();
        bit ok;
        int n;
        wait_rise(LIM, ok);
        sel = 3'd3;
        run_len(1'b1, n);
        check(n == exp_half(1), "R4 current high keeps old length", n, exp_half(1));
        run_len(1'b0, n);
        check(n == exp_half(1), "R4 following low keeps old length", n, exp_half(1));
        run_len(1'b1, n);
        check(n == exp_half(3), "R4 next high uses new length", n, exp_half(3));
    endtask

    task automatic t_change_mid_low();
        int n;
        sel = 3'd0;
        run_len(1'b0, n);
        check(n == exp_half(3), "R4 low in progress keeps old length", n, exp_half(3));
        run_len(1'b1, n);
        check(n == exp_half(0), "R4 next high after low uses new length", n, exp_half(0));
    endtask

    task automatic t_enter_manual();
        bit ok;
        int n;
        wait_rise(LIM, ok);
        manual = 1'b1;
        run_len(1'b1, n);
        check(n == exp_half(0), "R5 high completes on entering manual", n, exp_half(0));
        run_len(1'b0, n);
        check(n == LIM, "R5 output stays low in manual", n, LIM);
    endtask

    task automatic t_step_held();
        bit ok;
        int n;
        sel = 3'd1;
        btn = 1'b1;
        wait_rise(40, ok);
        check(ok, "R6 press gives a step", ok, 1);
        run_len(1'b1, n);
        check(n == exp_half(1), "R6 step high length", n, exp_half(1));
        run_len(1'b0, n);
        check(n == LIM, "R8 held button gives one step only", n, LIM);
        btn = 1'b0;
        repeat (20) smp();
    endtask

    task automatic t_filter();
        int r;
        repeat (10) begin
            btn = 1'b1; repeat (3) smp();
            btn = 1'b0; repeat (3) smp();
        end
        count_rises(80, r);
        check(r == 0, "R7 bouncing gives no step", r, 0);
        btn = 1'b1; repeat (DEB - 1) smp();
        btn = 1'b0;
        count_rises(80, r);
        check(r == 0, "R7 pulse one cycle short is rejected", r, 0);
        btn = 1'b1; repeat (DEB) smp();
        btn = 1'b0;
        count_rises(80, r);
        check(r == 1, "R7 pulse of exact length is accepted", r, 1);
        repeat (20) smp();
    endtask

    task automatic t_no_queue();
        bit ok;
        int n;
        int r;
        sel = 3'd2;
        btn = 1'b1;
        wait_rise(40, ok);
        btn = 1'b0;
        repeat (12) smp();
        btn = 1'b1;
        repeat (12) smp();
        btn = 1'b0;
        run_len(1'b1, n);
        count_rises(150, r);
        check(r == 0, "R9 press during step is dropped", r, 0);
    endtask

    task automatic t_resume_idle();
        bit ok;
        int n;
        manual = 1'b0;
        wait_rise(4, ok);
        check(ok, "R10 resume from idle at once", ok, 1);
        run_len(1'b1, n);
        check(n == exp_half(2), "R10 resumed high length", n, exp_half(2));
        run_len(1'b0, n);
        check(n == exp_half(2), "R10 resumed low length", n, exp_half(2));
    endtask

    task automatic t_resume_after_step();
        bit ok;
        int n;
        wait_rise(LIM, ok);
        manual = 1'b1;
        run_len(1'b1, n);
        run_len(1'b0, n);
        btn = 1'b1;
        wait_rise(40, ok);
        run_len(1'b1, n);
        check(n == exp_half(2), "R6 step high before resume", n, exp_half(2));
        manual = 1'b0;
        btn = 1'b0;
        run_len(1'b0, n);
        check(n == exp_half(2), "R10 step low completes before resume", n, exp_half(2));
        run_len(1'b1, n);
        check(n == exp_half(2), "R10 free-running high after step", n, exp_half(2));
    endtask

    task automatic t_reset_mid();
        bit ok;
        int n;
        sel = 3'd0;
        wait_rise(LIM, ok);
        wait_rise(LIM, ok);
        smp(); smp();
        rst_n = 1'b0;
        smp();
        check(cpu_clk == 1'b0, "R1 reset forces low mid-phase", cpu_clk, 0);
        smp();
        rst_n = 1'b1;
        wait_rise(4, ok);
        check(ok, "R1 restart after mid-run reset", ok, 1);
        run_len(1'b1, n);
        check(n == exp_half(0), "R1 full high after mid-run reset", n, exp_half(0));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        smp();
        t_reset();
        t_auto(0, "R2 rate sel 0");
        t_auto(2, "R2 rate sel 2");
        t_auto(7, "R3 select clamps to maximum");
        t_auto(1, "R2 rate sel 1");
        t_change_mid_high();
        t_change_mid_low();
        t_enter_manual();
        t_step_held();
        t_filter();
        t_no_queue();
        t_resume_idle();
        t_resume_after_step();
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule